// File: doc/BRIEF.md
# Programmable address window decoder

This block maps every transaction address onto a target ID. The mapping comes from a bank of address windows that software programs. Each window has four registers: a control word (enable and target), a security word (read-protect and write-protect), a low bound and a high bound. A global register holds the default target, which applies to any address that no enabled window covers. Software programs and reads back every register through a simple APB-style port: select, enable, write, address, write data and read data.

The decode port is purely combinational. It takes a 48-bit address, a write flag and a secure flag. It returns the target ID, a hit flag, the index of the matching window and a security-error flag. Window bounds have a granularity of 1 MB. Each bound register holds the byte address shifted right by 16, so register bits [31:4] carry address bits [47:20] and bits [3:0] always read as zero. The high bound names the last MB page of the window, so the window ends inclusively. Window 0 comes out of reset already enabled and covering the first megabyte. The internal configuration space therefore stays reachable while software disables and reprograms the other windows.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, window 0 is enabled with target 0 and both bounds 0, so it covers address 0x0 to 0xFFFFF. Windows 1 to 7 are disabled with all fields 0, and the default target is 0.
- R2: Register map on reg_addr[8:0]:
  - Window w occupies offsets w*16 + {0: control, 4: security, 8: low bound, 12: high bound}.
  - The default target sits at 0x100, bits [3:0].
  - An access takes effect when reg_sel, reg_en and reg_write are all 1. The stored value is visible on reg_rdata and at the decode port from the next cycle on.
  - The bound registers read back with bits [3:0] as zero.
- R3: Control bit 0 enables a window. A window with bit 0 clear never matches, whatever its bounds.
- R4: An enabled window matches when low[31:4] <= dec_addr[47:20] <= high[31:4]. Both bounds are inclusive, so the first address past the window is (high + 0x10) << 16.
- R5: On a match, dec_hit is 1, dec_win is the window index and dec_target is that window's control bits [7:4].
- R6: When no enabled window matches, dec_hit is 0, dec_win is 0, dec_sec_err is 0 and dec_target is the default target.
- R7: When several enabled windows match, the one with the lowest index wins.
- R8: Security word bit 0 marks a window write-secure and bit 1 marks it read-secure. dec_sec_err is 1 in two cases: a non-secure write hits a write-secure window, or a non-secure read hits a read-secure window. A secure access never raises it. The target is still reported on an error.
- R9: A window access whose index, reg_addr[7:4], is 8 or more changes no register, and reading it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 1 | Register port select |
| reg_en | input | 1 | Register port access phase |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| dec_addr | input | 48 | Transaction address |
| dec_write | input | 1 | Transaction is a write |
| dec_secure | input | 1 | Transaction is secure |
| dec_target | output | 4 | Resolved target ID |
| dec_hit | output | 1 | An enabled window matched |
| dec_win | output | 3 | Index of the matching window |
| dec_sec_err | output | 1 | Security violation on the matching window |

## Verification
The bench probes the first and last byte of a window and the bytes just outside it on both sides. A design that treated the high bound as exclusive would miss the window's final megabyte. A design that compared the wrong address bits would accept the byte just past the end. Overlapping windows are enabled and then disabled one at a time. This exposes a priority encoder that picks the highest index, and an enable bit that does not gate matching. Out-of-range window indices are written with values that would corrupt window 0 if the upper index bit were dropped. The read-secure and write-secure bits are set one at a time. This catches swapped security bits and an error raised on secure or unmatched traffic.

// File: rtl/awd_pkg.sv
package awd_pkg;
  // Register slot inside one window's 16-byte block
  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_SEC  = 2'd1,
    SLOT_LO   = 2'd2,
    SLOT_HI   = 2'd3
  } slot_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_TGT_LSB = 4;
  localparam int SEC_WS_BIT   = 0;
  localparam int SEC_RS_BIT   = 1;
  localparam int PG_REG_LSB   = 4;   // page field starts at this register bit
  localparam int PG_SHIFT     = 20;  // 1 MB granularity
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int WIN_W   = 3,
  parameter int TGT_W   = 4,
  parameter int PG_W    = 28,
  parameter int DATA_W  = 32,
  parameter int RA_W    = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_sel,
  input  logic                            reg_en,
  input  logic                            reg_write,
  input  logic [RA_W-1:0]                 reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  output logic [DATA_W-1:0]               reg_rdata,
  output logic [NUM_WIN-1:0]              win_en,
  output logic [NUM_WIN-1:0][TGT_W-1:0]   win_tgt,
  output logic [NUM_WIN-1:0]              win_ws,
  output logic [NUM_WIN-1:0]              win_rs,
  output logic [NUM_WIN-1:0][PG_W-1:0]    win_lo,
  output logic [NUM_WIN-1:0][PG_W-1:0]    win_hi,
  output logic [TGT_W-1:0]                dflt_tgt
);
  localparam int IDX_W = RA_W - 5;

  logic [IDX_W-1:0] idx;
  logic [WIN_W-1:0] idx_s;
  slot_e            slot;
  logic             is_glob, idx_ok, acc_wr, wr_win, wr_glob, wr_oob;

  assign idx     = reg_addr[RA_W-2:4];
  assign idx_s   = idx[WIN_W-1:0];
  assign slot    = slot_e'(reg_addr[3:2]);
  assign is_glob = reg_addr[RA_W-1];
  assign idx_ok  = (32'(idx) < NUM_WIN);
  assign acc_wr  = reg_sel & reg_en & reg_write;
  assign wr_win  = acc_wr & ~is_glob & idx_ok;
  assign wr_glob = acc_wr & is_glob;
  assign wr_oob  = acc_wr & ~is_glob & ~idx_ok;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel_w;
    assign sel_w = wr_win && (32'(idx) == w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_en[w]  <= (w == 0);
        win_tgt[w] <= '0;
        win_ws[w]  <= 1'b0;
        win_rs[w]  <= 1'b0;
        win_lo[w]  <= '0;
        win_hi[w]  <= '0;
      end else if (sel_w) begin
        case (slot)
          SLOT_CTRL: begin
            win_en[w]  <= reg_wdata[CTRL_EN_BIT];
            win_tgt[w] <= reg_wdata[CTRL_TGT_LSB +: TGT_W];
          end
          SLOT_SEC: begin
            win_ws[w] <= reg_wdata[SEC_WS_BIT];
            win_rs[w] <= reg_wdata[SEC_RS_BIT];
          end
          SLOT_LO: win_lo[w] <= reg_wdata[PG_REG_LSB +: PG_W];
          default: win_hi[w] <= reg_wdata[PG_REG_LSB +: PG_W];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dflt_tgt <= '0;
    else if (wr_glob) dflt_tgt <= reg_wdata[TGT_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (is_glob) begin
      reg_rdata[TGT_W-1:0] = dflt_tgt;
    end else if (idx_ok) begin
      case (slot)
        SLOT_CTRL: begin
          reg_rdata[CTRL_EN_BIT]               = win_en[idx_s];
          reg_rdata[CTRL_TGT_LSB +: TGT_W]     = win_tgt[idx_s];
        end
        SLOT_SEC: begin
          reg_rdata[SEC_WS_BIT] = win_ws[idx_s];
          reg_rdata[SEC_RS_BIT] = win_rs[idx_s];
        end
        SLOT_LO: reg_rdata[PG_REG_LSB +: PG_W] = win_lo[idx_s];
        default: reg_rdata[PG_REG_LSB +: PG_W] = win_hi[idx_s];
      endcase
    end
  end

  // R2
  glob_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_glob |=> dflt_tgt == $past(reg_wdata[TGT_W-1:0]));

  // R9
  oob_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oob |=> ($stable(win_en) && $stable(win_tgt) && $stable(win_ws) &&
                $stable(win_rs) && $stable(win_lo) && $stable(win_hi)));
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match #(
  parameter int PG_W = 28
) (
  input  logic            en,
  input  logic [PG_W-1:0] lo,
  input  logic [PG_W-1:0] hi,
  input  logic [PG_W-1:0] pg,
  output logic            hit
);
  function automatic logic in_span(input logic [PG_W-1:0] p, l, h);
    return (p >= l) && (p <= h);
  endfunction

  assign hit = en & in_span(pg, lo, hi);
endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_WIN = 8,
  parameter int TGT_W   = 4,
  parameter int DATA_W  = 32,
  parameter int RA_W    = 9
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       reg_sel,
  input  logic                                       reg_en,
  input  logic                                       reg_write,
  input  logic [RA_W-1:0]                            reg_addr,
  input  logic [DATA_W-1:0]                          reg_wdata,
  output logic [DATA_W-1:0]                          reg_rdata,
  input  logic [ADDR_W-1:0]                          dec_addr,
  input  logic                                       dec_write,
  input  logic                                       dec_secure,
  output logic [TGT_W-1:0]                           dec_target,
  output logic                                       dec_hit,
  output logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] dec_win,
  output logic                                       dec_sec_err
);
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int PG_W  = ADDR_W - PG_SHIFT;

  logic [NUM_WIN-1:0]            win_en, win_ws, win_rs, match_vec;
  logic [NUM_WIN-1:0][TGT_W-1:0] win_tgt;
  logic [NUM_WIN-1:0][PG_W-1:0]  win_lo, win_hi;
  logic [TGT_W-1:0]              dflt_tgt;
  logic [PG_W-1:0]               dec_pg;
  logic                          any_hit;
  logic [WIN_W-1:0]              pick;

  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PG_SHIFT];
  endfunction

  function automatic logic sec_violation(input logic wr, sec, ws, rs);
    return !sec && (wr ? ws : rs);
  endfunction

  awd_regfile #(
    .NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .TGT_W(TGT_W),
    .PG_W(PG_W), .DATA_W(DATA_W), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_en(reg_en), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .win_en(win_en), .win_tgt(win_tgt), .win_ws(win_ws), .win_rs(win_rs),
    .win_lo(win_lo), .win_hi(win_hi), .dflt_tgt(dflt_tgt)
  );

  assign dec_pg = page_of(dec_addr);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    awd_win_match #(.PG_W(PG_W)) u_match (
      .en(win_en[w]), .lo(win_lo[w]), .hi(win_hi[w]),
      .pg(dec_pg), .hit(match_vec[w])
    );
  end

  awd_prio_pick #(.N(NUM_WIN), .IDX_W(WIN_W)) u_pick (
    .req(match_vec), .any(any_hit), .idx(pick)
  );

  assign dec_hit     = any_hit;
  assign dec_win     = pick;
  assign dec_target  = any_hit ? win_tgt[pick] : dflt_tgt;
  assign dec_sec_err = any_hit &&
                       sec_violation(dec_write, dec_secure, win_ws[pick], win_rs[pick]);

  // R7
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> (match_vec & ((NUM_WIN'(1) << dec_win) - NUM_WIN'(1))) == '0);

  // R5
  hit_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> (win_en[dec_win] && dec_target == win_tgt[dec_win]));

  // R4
  hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> (dec_addr[ADDR_W-1:PG_SHIFT] >= win_lo[dec_win] &&
                 dec_addr[ADDR_W-1:PG_SHIFT] <= win_hi[dec_win]));

  // R6
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (dec_target == dflt_tgt && dec_win == '0 && !dec_sec_err));

  // R8
  secure_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_secure |-> !dec_sec_err);
endmodule

// File: tb/sim_addr_win_decoder.sv
module sim_addr_win_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 0, reg_en = 0, reg_write = 0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [47:0] dec_addr = '0;
  logic        dec_write = 0, dec_secure = 0;
  logic [3:0]  dec_target;
  logic        dec_hit;
  logic [2:0]  dec_win;
  logic        dec_sec_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  addr_win_decoder u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_en(reg_en), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dec_addr(dec_addr), .dec_write(dec_write), .dec_secure(dec_secure),
    .dec_target(dec_target), .dec_hit(dec_hit), .dec_win(dec_win),
    .dec_sec_err(dec_sec_err)
  );

  // Bound register image of a byte address: shift right by 16, low nibble cleared
  function automatic logic [31:0] bound_reg(input logic [47:0] a);
    logic [47:0] s;
    s = a >> 16;
    return s[31:0] & 32'hFFFF_FFF0;
  endfunction

  function automatic logic [8:0] woff(input int w, input int slot);
    return 9'(w * 16 + slot * 4);
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_write = 1; reg_addr = a; reg_wdata = d; reg_en = 0;
    @(negedge clk);
    reg_en = 1;
    @(negedge clk);
    reg_sel = 0; reg_en = 0; reg_write = 0;
  endtask

  task automatic reg_rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = 1; reg_write = 0; reg_addr = a; reg_en = 1;
    #1 check(req, 48'(reg_rdata), 48'(exp));
    @(negedge clk);
    reg_sel = 0; reg_en = 0;
  endtask

  task automatic dec_chk(input string req, input logic [47:0] a, input logic wr, sec,
                         input logic hit, input logic [2:0] win, input logic [3:0] tgt,
                         input logic err);
    @(negedge clk);
    dec_addr = a; dec_write = wr; dec_secure = sec;
    #1;
    check({req, " hit"}, 48'(dec_hit), 48'(hit));
    check({req, " win"}, 48'(dec_win), 48'(win));
    check({req, " target"}, 48'(dec_target), 48'(tgt));
    check({req, " sec_err"}, 48'(dec_sec_err), 48'(err));
  endtask

  // R1: reset contents and window 0 coverage
  task automatic t_reset();
    reg_rd_chk("R1 ctrl0", woff(0, 0), 32'h1);
    reg_rd_chk("R1 ctrl1", woff(1, 0), 32'h0);
    reg_rd_chk("R1 hi0", woff(0, 3), 32'h0);
    reg_rd_chk("R1 default", 9'h100, 32'h0);
    dec_chk("R1 first MB", 48'h0_000F_FFFF, 0, 0, 1, 0, 0, 0);
    dec_chk("R1 past first MB", 48'h0_0010_0000, 0, 0, 0, 0, 0, 0);
  endtask

  // R2/R6: register readback, masking, default target
  task automatic t_regs();
    reg_wr(woff(3, 2), 32'hABCD_E12F);
    reg_rd_chk("R2 lo masked", woff(3, 2), 32'hABCD_E120);
    reg_wr(woff(3, 3), 32'h0000_001F);
    reg_rd_chk("R2 hi masked", woff(3, 3), 32'h0000_0010);
    reg_wr(woff(3, 1), 32'h3);
    reg_rd_chk("R2 sec", woff(3, 1), 32'h3);
    reg_wr(woff(3, 1), 32'h0);
    reg_wr(9'h100, 32'hFFFF_FFF5);
    reg_rd_chk("R2 default", 9'h100, 32'h5);
    dec_chk("R6 miss uses default", 48'h7777_0000_0000, 1, 0, 0, 0, 5, 0);
  endtask

  // R4/R5: inclusive range on a programmed window
  task automatic t_range();
    reg_wr(woff(2, 2), bound_reg(48'h1234_0000_0000));
    reg_wr(woff(2, 3), bound_reg(48'h1234_002F_FFFF));
    reg_wr(woff(2, 0), 32'h71);
    reg_rd_chk("R5 ctrl readback", woff(2, 0), 32'h71);
    dec_chk("R4 base", 48'h1234_0000_0000, 0, 1, 1, 2, 7, 0);
    dec_chk("R4 last byte", 48'h1234_002F_FFFF, 1, 1, 1, 2, 7, 0);
    dec_chk("R4 end exclusive", 48'h1234_0030_0000, 0, 1, 0, 0, 5, 0);
    dec_chk("R4 below base", 48'h1233_FFFF_FFFF, 0, 1, 0, 0, 5, 0);
  endtask

  // R3: enable bit gates matching; window 0 keeps working
  task automatic t_enable();
    reg_wr(woff(2, 0), 32'h70);
    dec_chk("R3 disabled window", 48'h1234_0010_0000, 0, 1, 0, 0, 5, 0);
    dec_chk("R3 window0 still live", 48'h0_0000_1000, 0, 1, 1, 0, 0, 0);
    reg_wr(woff(2, 0), 32'h71);
    dec_chk("R3 re-enabled", 48'h1234_0010_0000, 0, 1, 1, 2, 7, 0);
  endtask

  // R7: overlapping windows, lowest index wins
  task automatic t_overlap();
    reg_wr(woff(5, 2), bound_reg(48'h1234_0000_0000));
    reg_wr(woff(5, 3), bound_reg(48'h1234_00FF_FFFF));
    reg_wr(woff(5, 0), 32'h91);
    dec_chk("R7 lower wins", 48'h1234_0020_0000, 0, 1, 1, 2, 7, 0);
    dec_chk("R7 only upper", 48'h1234_0080_0000, 0, 1, 1, 5, 9, 0);
    reg_wr(woff(2, 0), 32'h70);
    dec_chk("R7 after lower off", 48'h1234_0020_0000, 0, 1, 1, 5, 9, 0);
  endtask

  // R8: security attributes on window 5
  task automatic t_security();
    reg_wr(woff(5, 1), 32'h1);  // write-secure only
    dec_chk("R8 ns write ws", 48'h1234_0040_0000, 1, 0, 1, 5, 9, 1);
    dec_chk("R8 ns read ws-only", 48'h1234_0040_0000, 0, 0, 1, 5, 9, 0);
    dec_chk("R8 secure write", 48'h1234_0040_0000, 1, 1, 1, 5, 9, 0);
    reg_wr(woff(5, 1), 32'h2);  // read-secure only
    dec_chk("R8 ns read rs", 48'h1234_0040_0000, 0, 0, 1, 5, 9, 1);
    dec_chk("R8 ns write rs-only", 48'h1234_0040_0000, 1, 0, 1, 5, 9, 0);
    dec_chk("R8 miss no err", 48'h5000_0000_0000, 0, 0, 0, 0, 5, 0);
  endtask

  // R9: out-of-range window indices
  task automatic t_bounds();
    reg_wr(woff(8, 0), 32'hF0);     // would aliasing onto window 0 clear its enable
    reg_wr(woff(8, 3), 32'h0FFF_FFF0);
    reg_wr(woff(15, 2), 32'h1230);
    reg_rd_chk("R9 read idx8", woff(8, 0), 32'h0);
    reg_rd_chk("R9 read idx15", woff(15, 2), 32'h0);
    reg_rd_chk("R9 ctrl0 intact", woff(0, 0), 32'h1);
    reg_rd_chk("R9 hi0 intact", woff(0, 3), 32'h0);
    reg_rd_chk("R9 lo7 intact", woff(7, 2), 32'h0);
    dec_chk("R9 window0 decode", 48'h0_0000_0040, 1, 0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_range();
    t_enable();
    t_overlap();
    t_security();
    t_bounds();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule